// File: doc/BRIEF.md
# Break-2 and External Trigger Source Selector

This block is a single write-protected control register placed ahead of a PWM timer's fault input and external trigger input. Software writes one word through a simple register port. The stored fields decide which raw fault sources feed the timer's second break request: a dedicated fault pin, comparator 1 and comparator 2. Comparator 2 can be inverted before use. Every enabled source is ORed into one active-high request. A separate field chooses whether the timer's external trigger comes from the legacy trigger pin or from one of the two comparators.

The break path is purely combinational. A fault therefore reaches the timer in the same cycle that it appears. Only the register storage is clocked. A 2-bit lock level input freezes the whole register once any non-zero level is applied. After that, a stray write cannot disconnect a protection source.

Top module: `brkopt_top`

## Requirements
- R1: After synchronous reset the register reads back 0x0000_0001. Only the fault pin source is enabled.
- R2: A write with `wr_en` high, `addr` equal to 0x60 and lock level zero stores the writable fields at the next clock edge. The fields are: bit 0 fault pin enable, bit 1 comparator-1 enable, bit 2 comparator-2 enable, bit 11 comparator-2 polarity and bits 16:14 trigger select.
- R3: `brk2_req` is the OR of the enabled sources. It follows its inputs within the same cycle. It is low when no source is enabled.
- R4: With bit 11 clear, comparator 2 is active high. With bit 11 set, it is active low and the block inverts it before the OR.
- R5: Trigger select code 000 routes `etr_pin`, code 001 routes `cmp1_out` and code 010 routes `cmp2_out` to `etr_out`.
- R6: A stored trigger select code from 011 to 111 routes `etr_pin` to `etr_out`.
- R7: All bit positions outside 0, 1, 2, 11 and 16:14 read as zero whatever was written. The writable mask is 0x0001_C807.
- R8: While `lock_lvl` is non-zero, writes are ignored and every field keeps its value.
- R9: A write to any other address leaves the register unchanged. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (8) | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data; the register word when `addr` matches, otherwise zero |
| lock_lvl | input | 2 | Lock level; any non-zero value freezes the register |
| brk2_pin | input | 1 | Dedicated break-2 fault pin, active high |
| cmp1_out | input | 1 | Comparator 1 output |
| cmp2_out | input | 1 | Comparator 2 output |
| etr_pin | input | 1 | Legacy external trigger pin |
| brk2_req | output | 1 | Combined break-2 request, active high |
| etr_out | output | 1 | Selected external trigger |

## Verification
The assertions assume that `lock_lvl`, `addr`, `wr_en` and `wr_data` are stable around each rising edge. They also assume that the fault and comparator inputs are never X while reset is low, because the break properties compare those inputs directly with `brk2_req`. The bench changes every input only on the falling edge and always drives known values. Its random stimulus favours the register's own address and lock level zero, so that writes actually land often enough to move the register through many field combinations.

// File: rtl/brkopt_pkg.sv
package brkopt_pkg;

  localparam int DATA_W       = 32;
  localparam int PIN_EN_BIT   = 0;
  localparam int CMP1_EN_BIT  = 1;
  localparam int CMP2_EN_BIT  = 2;
  localparam int CMP2_POL_BIT = 11;
  localparam int TRG_LSB      = 14;
  localparam int TRG_W        = 3;
  localparam int TRG_MSB      = TRG_LSB + TRG_W - 1;
  localparam int NUM_SRC      = 3;

  localparam logic [TRG_W-1:0] TRG_CODE_PIN  = 3'd0;
  localparam logic [TRG_W-1:0] TRG_CODE_CMP1 = 3'd1;
  localparam logic [TRG_W-1:0] TRG_CODE_CMP2 = 3'd2;

  typedef struct packed {
    logic [TRG_W-1:0] trg_sel;
    logic             cmp2_pol;
    logic             cmp2_en;
    logic             cmp1_en;
    logic             pin_en;
  } opt_fields_t;

  localparam opt_fields_t RESET_FIELDS = '{trg_sel: TRG_CODE_PIN, cmp2_pol: 1'b0,
                                           cmp2_en: 1'b0, cmp1_en: 1'b0, pin_en: 1'b1};

  localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << PIN_EN_BIT) | (DATA_W'(1) << CMP1_EN_BIT) |
      (DATA_W'(1) << CMP2_EN_BIT) | (DATA_W'(1) << CMP2_POL_BIT) |
      (DATA_W'((1 << TRG_W) - 1) << TRG_LSB);

  function automatic logic [DATA_W-1:0] to_word(input opt_fields_t f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PIN_EN_BIT]        = f.pin_en;
    w[CMP1_EN_BIT]       = f.cmp1_en;
    w[CMP2_EN_BIT]       = f.cmp2_en;
    w[CMP2_POL_BIT]      = f.cmp2_pol;
    w[TRG_MSB:TRG_LSB]   = f.trg_sel;
    return w;
  endfunction

endpackage

// File: rtl/brkopt_reg.sv
module brkopt_reg
  import brkopt_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h60,
  parameter int              LOCK_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [LOCK_W-1:0]   lock_lvl,
  output opt_fields_t         fields,
  output logic [DATA_W-1:0]   rd_data
);

  logic        hit;
  logic        locked;
  opt_fields_t wr_fields;
  logic        unused_wr_bits;

  assign hit    = (addr == OFFSET);
  assign locked = |lock_lvl;

  always_comb begin
    wr_fields.pin_en   = wr_data[PIN_EN_BIT];
    wr_fields.cmp1_en  = wr_data[CMP1_EN_BIT];
    wr_fields.cmp2_en  = wr_data[CMP2_EN_BIT];
    wr_fields.cmp2_pol = wr_data[CMP2_POL_BIT];
    wr_fields.trg_sel  = wr_data[TRG_MSB:TRG_LSB];
  end

  // Reserved positions are not stored at all.
  assign unused_wr_bits = ^(wr_data & ~FIELD_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= RESET_FIELDS;
    end else if (wr_en && hit && !locked) begin
      fields <= wr_fields;
    end
  end

  assign rd_data = hit ? to_word(fields) : '0;

endmodule

// File: rtl/brkopt_combine.sv
module brkopt_combine #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] src_raw,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_inv,
  output logic            brk_out
);

  logic [NSRC-1:0] qualified;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign qualified[i] = (src_raw[i] ^ src_inv[i]) & src_en[i];
  end

  assign brk_out = |qualified;

endmodule

// File: rtl/brkopt_trgmux.sv
module brkopt_trgmux
  import brkopt_pkg::*;
(
  input  logic [TRG_W-1:0] sel,
  input  logic             legacy_in,
  input  logic             cmp1_in,
  input  logic             cmp2_in,
  output logic             trg_out
);

  always_comb begin
    case (sel)
      TRG_CODE_CMP1: trg_out = cmp1_in;
      TRG_CODE_CMP2: trg_out = cmp2_in;
      default:       trg_out = legacy_in;
    endcase
  end

endmodule

// File: rtl/brkopt_top.sv
module brkopt_top
  import brkopt_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h60,
  parameter int              LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic              brk2_pin,
  input  logic              cmp1_out,
  input  logic              cmp2_out,
  input  logic              etr_pin,
  output logic              brk2_req,
  output logic              etr_out
);

  opt_fields_t         fields;
  logic [NUM_SRC-1:0]  src_raw;
  logic [NUM_SRC-1:0]  src_en;
  logic [NUM_SRC-1:0]  src_inv;

  brkopt_reg #(.ADDR_W(ADDR_W), .OFFSET(OFFSET), .LOCK_W(LOCK_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .lock_lvl (lock_lvl),
    .fields   (fields),
    .rd_data  (rd_data)
  );

  assign src_raw = {cmp2_out, cmp1_out, brk2_pin};
  assign src_en  = {fields.cmp2_en, fields.cmp1_en, fields.pin_en};
  assign src_inv = {fields.cmp2_pol, 1'b0, 1'b0};

  brkopt_combine #(.NSRC(NUM_SRC)) u_combine (
    .src_raw (src_raw),
    .src_en  (src_en),
    .src_inv (src_inv),
    .brk_out (brk2_req)
  );

  brkopt_trgmux u_trgmux (
    .sel       (fields.trg_sel),
    .legacy_in (etr_pin),
    .cmp1_in   (cmp1_out),
    .cmp2_in   (cmp2_out),
    .trg_out   (etr_out)
  );

endmodule

// File: rtl/brkopt_chk.sv
module brkopt_chk
  import brkopt_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h60,
  parameter int              LOCK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic [LOCK_W-1:0] lock_lvl,
  input logic              brk2_pin,
  input logic              cmp1_out,
  input logic              cmp2_out,
  input logic              etr_pin,
  input logic              brk2_req,
  input logic              etr_out,
  input opt_fields_t       fields
);

  a_r1_reset_value: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (fields == RESET_FIELDS));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFFSET && lock_lvl == '0) |=> (to_word(fields) == ($past(wr_data) & FIELD_MASK)));

  a_r3_pin_forces: assert property (@(posedge clk) disable iff (rst)
    (fields.pin_en && brk2_pin) |-> brk2_req);

  a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!fields.pin_en && !fields.cmp1_en && !fields.cmp2_en) |-> !brk2_req);

  a_r4_cmp2_polarity: assert property (@(posedge clk) disable iff (rst)
    (fields.cmp2_en && (cmp2_out != fields.cmp2_pol)) |-> brk2_req);

  a_r5_cmp1_route: assert property (@(posedge clk) disable iff (rst)
    (fields.trg_sel == TRG_CODE_CMP1) |-> (etr_out == cmp1_out));

  a_r6_reserved_code: assert property (@(posedge clk) disable iff (rst)
    (fields.trg_sel > TRG_CODE_CMP2) |-> (etr_out == etr_pin));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == OFFSET) |-> ((rd_data & ~FIELD_MASK) == '0));

  a_r8_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (lock_lvl != '0) |=> $stable(fields));

  a_r9_other_addr: assert property (@(posedge clk) disable iff (rst)
    (addr != OFFSET) |-> (rd_data == '0));

endmodule

bind brkopt_top brkopt_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET), .LOCK_W(LOCK_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .lock_lvl (lock_lvl),
  .brk2_pin (brk2_pin),
  .cmp1_out (cmp1_out),
  .cmp2_out (cmp2_out),
  .etr_pin  (etr_pin),
  .brk2_req (brk2_req),
  .etr_out  (etr_out),
  .fields   (fields)
);

// File: tb/brkopt_top_bench.sv
module brkopt_top_bench;

  localparam int              AW   = 8;
  localparam logic [AW-1:0]   OFF  = 8'h60;
  localparam logic [31:0]     MASK = 32'h0001_C807;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = OFF;
  logic [31:0]   wr_data = '0;
  logic [1:0]    lock = '0;
  logic          pin = 1'b0, c1 = 1'b0, c2 = 1'b0, etr = 1'b0;
  logic [31:0]   rd;
  logic          brk, trg;

  int          checks = 0;
  int          failures = 0;
  logic [31:0] model = 32'h1;

  always #2 clk = ~clk;

  brkopt_top u_brkopt_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd), .lock_lvl(lock), .brk2_pin(pin), .cmp1_out(c1),
    .cmp2_out(c2), .etr_pin(etr), .brk2_req(brk), .etr_out(trg)
  );

  function automatic logic exp_brk(logic [31:0] r, logic p, logic a, logic b);
    return (r[0] & p) | (r[1] & a) | (r[2] & (b ^ r[11]));
  endfunction

  function automatic logic exp_trg(logic [31:0] r, logic e, logic a, logic b);
    case (r[16:14])
      3'd1:    return a;
      3'd2:    return b;
      default: return e;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [1:0] l);
    @(negedge clk);
    addr = a; wr_data = d; lock = l; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == OFF && l == 2'd0) model = d & MASK;
    addr = OFF;
    #1;
  endtask

  task automatic set_in(logic [3:0] v);
    pin = v[0]; c1 = v[1]; c2 = v[2]; etr = v[3];
    #1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " rd"}, rd, model);
    chk({tag, " brk"}, {31'b0, brk}, {31'b0, exp_brk(model, pin, c1, c2)});
    chk({tag, " trg"}, {31'b0, trg}, {31'b0, exp_trg(model, etr, c1, c2)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset value", rd, 32'h0000_0001);
    set_in(4'b0001);
    chk("R1 pin source live after reset", {31'b0, brk}, 32'h1);
    addr = OFF + 8'd1; #1;
    chk("R9 read other address", rd, 32'h0);
    addr = OFF; #1;

    // R3: every enable combination against every source pattern
    for (int m = 0; m < 8; m++) begin
      wr(OFF, 32'(m), 2'd0);
      chk("R2 enable write", rd, 32'(m));
      for (int v = 0; v < 8; v++) begin
        set_in(4'(v));
        chk("R3 break or", {31'b0, brk}, {31'b0, exp_brk(model, pin, c1, c2)});
      end
    end

    // R4: comparator-2 polarity
    wr(OFF, 32'h0000_0004, 2'd0);
    set_in(4'b0100); chk("R4 active high asserted", {31'b0, brk}, 32'h1);
    set_in(4'b0000); chk("R4 active high idle", {31'b0, brk}, 32'h0);
    wr(OFF, 32'h0000_0804, 2'd0);
    set_in(4'b0000); chk("R4 active low asserted", {31'b0, brk}, 32'h1);
    set_in(4'b0100); chk("R4 active low idle", {31'b0, brk}, 32'h0);

    // R5 / R6: every trigger select code
    for (int code = 0; code < 8; code++) begin
      wr(OFF, 32'(code) << 14, 2'd0);
      for (int v = 0; v < 16; v++) begin
        set_in(4'(v));
        if (code < 3) chk("R5 trigger route", {31'b0, trg}, {31'b0, exp_trg(model, etr, c1, c2)});
        else          chk("R6 reserved code uses pin", {31'b0, trg}, {31'b0, etr});
      end
    end

    // R7: reserved bits
    wr(OFF, 32'hFFFF_FFFF, 2'd0);
    chk("R7 reserved read zero", rd, MASK);

    // R8: locked writes
    wr(OFF, 32'h0000_4803, 2'd0);
    for (int l = 1; l < 4; l++) begin
      wr(OFF, 32'h0000_8004, 2'(l));
      chk("R8 locked write ignored", rd, 32'h0000_4803);
      set_in(4'b0010);
      chk("R8 locked break unchanged", {31'b0, brk}, 32'h1);
    end

    // R9: other address
    wr(OFF + 8'd4, 32'h0000_0000, 2'd0);
    chk("R9 other address write ignored", rd, 32'h0000_4803);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [1:0]    l;
      a = ($urandom % 4 == 0) ? AW'($urandom) : OFF;
      l = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      wr(a, $urandom, l);
      set_in(4'($urandom));
      check_all("R2 R3 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule